// File: doc/BRIEF.md
# EPP Bus Cycle Sequencer

This block turns a single host I/O read or write, aimed at one of the enhanced-parallel-port offsets, into one handshaken transfer on the peripheral cable. An access to the lowest offset of the window (3) is an address transfer and uses the address strobe. Accesses to offsets 4 to 7 are data transfers and use the data strobe. The host is held in a wait state through its ready line while the transfer runs. The transfer ends when the peripheral's wait line has been high for a minimum settle interval. If the peripheral never answers, a long timeout ends the transfer instead.

The host strobes and the peripheral wait line are asynchronous. Each passes through a two-flop synchronizer before the sequencer uses it. Both the start of a transfer and its end are gated by a settle counter on the synchronized wait level. If a transfer is aborted by the timeout, a sticky status bit is set. Software clears that bit by writing a one to bit 0 of the status offset. The bit is also cleared whenever the port mode input drops.

The peripheral data bus is split into an input, an output and an output enable, for a pad ring or a tri-state wrapper outside the block.

Top module: `epp_cycle_seq`

## Requirements
- R1: A transfer at offset 3 drives `pp_astb_n` low and leaves `pp_dstb_n` high. A transfer at offsets 4 to 7 drives `pp_dstb_n` low and leaves `pp_astb_n` high. The two strobes are never low together.
- R2: `host_rdy` drops combinationally, in the same cycle, when `host_cs` and `epp_mode` are high, `host_addr` is 3 to 7, and either host strobe is low. It stays high for offsets 0 to 2 and whenever `epp_mode` is low, and no peripheral strobe then moves.
- R3: `pp_write_n` and the selected strobe stay high until the synchronized `pp_wait` has been low for SETTLE_CYC (default 2) clock cycles. When `pp_wait` is already settled low, the transfer proceeds without further delay. A fall of `pp_wait` becomes a fall of `pp_write_n` on the fifth clock edge.
- R4: On a write, `pp_write_n` falls one clock before the selected strobe falls. On a read, `pp_write_n` stays high throughout.
- R5: After the synchronized `pp_wait` has been high for SETTLE_CYC cycles, `host_rdy`, `pp_write_n` and the active strobe all return high on the same edge. A rise of `pp_wait` becomes the strobe release on the fifth clock edge.
- R6: If a transfer has not completed TIMEOUT_CYC cycles (default 240,000) after it started, it is aborted. The strobes and `pp_write_n` go high, `host_rdy` is released, and `timeout_flag` is set.
- R7: `timeout_flag` stays set until one of two events clears it: a host write to offset 1 with data bit 0 equal to 1, or `epp_mode` going low. A write to offset 1 with data bit 0 equal to 0 leaves it set.
- R8: On a read transfer, `pp_din` is captured on the edge that releases the strobe. It is then presented on `host_rdata` while `host_addr` is 3 to 7. At offset 1, `host_rdata` reads `timeout_flag` in bit 0 and zeros in bits 7 to 1.
- R9: `pp_doe` is high only during write transfers, from the fall of `pp_write_n` until the strobe is released. While it is high, `pp_dout` equals the host write data of that access.
- R10: After reset, `host_rdy`, `pp_write_n`, `pp_astb_n` and `pp_dstb_n` are high, and `pp_doe` and `timeout_flag` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| epp_mode | input | 1 | Port operates in enhanced mode; low clears the timeout bit |
| host_cs | input | 1 | Host chip select, qualifies the address |
| host_addr | input | 3 | Host port offset |
| host_rd_n | input | 1 | Host read strobe, active low, asynchronous |
| host_wr_n | input | 1 | Host write strobe, active low, asynchronous |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Captured read byte, or status at offset 1 |
| host_rdy | output | 1 | Host ready, low stalls the host access |
| timeout_flag | output | 1 | Sticky abort status |
| pp_write_n | output | 1 | Peripheral write line, low for writes |
| pp_astb_n | output | 1 | Peripheral address strobe, active low |
| pp_dstb_n | output | 1 | Peripheral data strobe, active low |
| pp_wait | input | 1 | Peripheral wait handshake, asynchronous |
| pp_din | input | 8 | Peripheral data bus input |
| pp_dout | output | 8 | Peripheral data bus output |
| pp_doe | output | 1 | Output enable for the peripheral data bus |

## Verification
The hardest situation to reach is a transfer that starts while the wait line is still high. The sequencer must then sit with every cable line idle and the host stalled, then count the settle interval from the moment wait drops. The bench holds wait high across the start of a write and checks that the cable stays idle for many cycles. It then drops wait at a known clock phase and counts the edges until the write line falls. Raising wait during the strobe measures the release edge the same way. The abort path is reached by a peripheral model that never raises wait, with TIMEOUT_CYC overridden to a short value.

// File: rtl/epp_seq_pkg.sv
package epp_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_ARM     = 3'd1,
    ST_SETUP   = 3'd2,
    ST_ACTIVE  = 3'd3,
    ST_RELEASE = 3'd4
  } seq_state_e;
endpackage

// File: rtl/epp_sync.sv
// Two-flop synchronizer bank with a per-bit reset value.
module epp_sync #(
  parameter int          W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= RST_VAL;
      stage2_q <= RST_VAL;
    end else begin
      stage1_q <= d_async;
      stage2_q <= stage1_q;
    end
  end

  assign q_sync = stage2_q;
endmodule

// File: rtl/epp_settle.sv
// Measures how long a synchronized level has been stable, separately for
// low (index 0) and high (index 1); each counter saturates at SETTLE_CYC.
module epp_settle #(
  parameter int SETTLE_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic low_ok,
  output logic high_ok
);
  localparam int CW = $clog2(SETTLE_CYC + 1);
  localparam logic [CW-1:0] SAT = CW'(SETTLE_CYC);

  logic [1:0] ok;

  for (genvar p = 0; p < 2; p++) begin : g_pol
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_d;
    logic          match;

    assign match = (lvl == p[0]);

    always_comb begin
      if (!match)          cnt_d = '0;
      else if (cnt_q == SAT) cnt_d = cnt_q;
      else                 cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
    end

    assign ok[p] = (cnt_q >= SAT);
  end

  assign low_ok  = ok[0];
  assign high_ok = ok[1];
endmodule

// File: rtl/epp_timeout.sv
// Cycle counter that runs while a transfer is in flight and flags the
// last cycle of the allowed window.
module epp_timeout #(
  parameter int TIMEOUT_CYC = 240000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expire
);
  localparam int TW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [TW-1:0] LAST = TW'(TIMEOUT_CYC - 1);

  logic [TW-1:0] cnt_q;
  logic [TW-1:0] cnt_d;
  logic          at_last;

  assign at_last = (cnt_q == LAST);

  always_comb begin
    if (!run)         cnt_d = '0;
    else if (at_last) cnt_d = cnt_q;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expire = run && at_last;
endmodule

// File: rtl/epp_cycle_seq.sv
module epp_cycle_seq
  import epp_seq_pkg::*;
#(
  parameter int DW           = 8,
  parameter int AW           = 3,
  parameter int SETTLE_CYC   = 2,
  parameter int TIMEOUT_CYC  = 240000,
  parameter int ADDR_STB_OFS = 3,
  parameter int STATUS_OFS   = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          epp_mode,
  input  logic          host_cs,
  input  logic [AW-1:0] host_addr,
  input  logic          host_rd_n,
  input  logic          host_wr_n,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  output logic          host_rdy,
  output logic          timeout_flag,
  output logic          pp_write_n,
  output logic          pp_astb_n,
  output logic          pp_dstb_n,
  input  logic          pp_wait,
  input  logic [DW-1:0] pp_din,
  output logic [DW-1:0] pp_dout,
  output logic          pp_doe
);
  localparam logic [AW-1:0] ASTB_OFS = AW'(ADDR_STB_OFS);
  localparam logic [AW-1:0] STAT_OFS = AW'(STATUS_OFS);

  // ---------------- synchronizers ----------------
  logic [2:0] async_in;
  logic [2:0] sync_out;
  logic       wait_s;
  logic       rd_s_n;
  logic       wr_s_n;
  logic       wr_s_n_q;

  assign async_in = {pp_wait, host_rd_n, host_wr_n};

  epp_sync #(.W(3), .RST_VAL(3'b111)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (async_in),
    .q_sync  (sync_out)
  );

  assign wait_s = sync_out[2];
  assign rd_s_n = sync_out[1];
  assign wr_s_n = sync_out[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_s_n_q <= 1'b1;
    else        wr_s_n_q <= wr_s_n;
  end

  // ---------------- settle and timeout ----------------
  logic low_ok;
  logic high_ok;
  logic expire;
  logic tmo_run;

  epp_settle #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
    .clk     (clk),
    .rst_n   (rst_n),
    .lvl     (wait_s),
    .low_ok  (low_ok),
    .high_ok (high_ok)
  );

  epp_timeout #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_tmo (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (tmo_run),
    .expire (expire)
  );

  // ---------------- address decode ----------------
  logic addr_hit;
  logic hit_raw;
  logic hit_sync;
  logic stat_clr;

  assign addr_hit = host_cs && epp_mode && (host_addr >= ASTB_OFS);
  assign hit_raw  = addr_hit && (!host_rd_n || !host_wr_n);
  assign hit_sync = addr_hit && (!rd_s_n || !wr_s_n);
  assign stat_clr = host_cs && (host_addr == STAT_OFS) && wr_s_n_q && !wr_s_n
                    && host_wdata[0];

  // ---------------- sequencer ----------------
  seq_state_e    state_q, state_d;
  logic          cyc_wr_q, cyc_wr_d;
  logic          cyc_adr_q, cyc_adr_d;
  logic [DW-1:0] wdata_q;
  logic          wdata_en;
  logic [DW-1:0] rdata_q;
  logic          rdata_en;
  logic          abort_hit;
  logic          flag_q, flag_d;

  assign tmo_run   = (state_q == ST_ARM) || (state_q == ST_SETUP) ||
                     (state_q == ST_ACTIVE);
  assign abort_hit = epp_mode && expire &&
                     ((state_q == ST_ARM) || (state_q == ST_ACTIVE));

  always_comb begin
    state_d   = state_q;
    cyc_wr_d  = cyc_wr_q;
    cyc_adr_d = cyc_adr_q;
    wdata_en  = 1'b0;
    rdata_en  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (hit_sync) begin
          state_d   = ST_ARM;
          cyc_wr_d  = !wr_s_n;
          cyc_adr_d = (host_addr == ASTB_OFS);
          wdata_en  = 1'b1;
        end
      end
      ST_ARM: begin
        if (expire)      state_d = ST_RELEASE;
        else if (low_ok) state_d = ST_SETUP;
      end
      ST_SETUP: begin
        state_d = ST_ACTIVE;
      end
      ST_ACTIVE: begin
        if (expire || high_ok) begin
          state_d  = ST_RELEASE;
          rdata_en = !cyc_wr_q;
        end
      end
      ST_RELEASE: begin
        if (rd_s_n && wr_s_n) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
    if (!epp_mode) begin
      state_d  = ST_IDLE;
      wdata_en = 1'b0;
      rdata_en = 1'b0;
    end
  end

  always_comb begin
    flag_d = flag_q;
    if (!epp_mode || stat_clr) flag_d = 1'b0;
    if (abort_hit)             flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      cyc_wr_q  <= 1'b0;
      cyc_adr_q <= 1'b0;
      flag_q    <= 1'b0;
    end else begin
      state_q   <= state_d;
      cyc_wr_q  <= cyc_wr_d;
      cyc_adr_q <= cyc_adr_d;
      flag_q    <= flag_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        wdata_q <= '0;
    else if (wdata_en) wdata_q <= host_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rdata_q <= '0;
    else if (rdata_en) rdata_q <= pp_din;
  end

  // ---------------- outputs ----------------
  logic drive_phase;
  assign drive_phase = (state_q == ST_SETUP) || (state_q == ST_ACTIVE);

  assign pp_write_n   = !(drive_phase && cyc_wr_q);
  assign pp_doe       = drive_phase && cyc_wr_q;
  assign pp_dout      = wdata_q;
  assign pp_astb_n    = !((state_q == ST_ACTIVE) && cyc_adr_q);
  assign pp_dstb_n    = !((state_q == ST_ACTIVE) && !cyc_adr_q);
  assign host_rdy     = !(hit_raw && (state_q != ST_RELEASE));
  assign timeout_flag = flag_q;
  assign host_rdata   = (host_addr == STAT_OFS) ? {{(DW-1){1'b0}}, flag_q}
                                                : rdata_q;
endmodule

// File: rtl/epp_cycle_seq_chk.sv
module epp_cycle_seq_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          host_rdy,
  input logic          timeout_flag,
  input logic          pp_write_n,
  input logic          pp_astb_n,
  input logic          pp_dstb_n,
  input logic          pp_wait,
  input logic          pp_doe,
  input logic [DW-1:0] pp_dout,
  input logic          abort_hit
);
  assert_one_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (pp_astb_n || pp_dstb_n));

  assert_write_settled_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pp_write_n) |-> (!$past(pp_wait, 4) && !$past(pp_wait, 5)));

  assert_write_before_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (($fell(pp_astb_n) || $fell(pp_dstb_n)) && !pp_write_n) |-> $past(!pp_write_n));

  assert_release_settled_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (($rose(pp_astb_n) || $rose(pp_dstb_n)) && !$past(abort_hit))
      |-> ($past(pp_wait, 4) && $past(pp_wait, 5)));

  assert_abort_releases_R6: assert property (@(posedge clk) disable iff (!rst_n)
    abort_hit |=> (timeout_flag && pp_astb_n && pp_dstb_n && pp_write_n));

  assert_drive_only_writing_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pp_doe |-> !pp_write_n);

  assert_dout_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pp_doe && $past(pp_doe)) |-> $stable(pp_dout));
endmodule

bind epp_cycle_seq epp_cycle_seq_chk #(.DW(DW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .host_rdy     (host_rdy),
  .timeout_flag (timeout_flag),
  .pp_write_n   (pp_write_n),
  .pp_astb_n    (pp_astb_n),
  .pp_dstb_n    (pp_dstb_n),
  .pp_wait      (pp_wait),
  .pp_doe       (pp_doe),
  .pp_dout      (pp_dout),
  .abort_hit    (abort_hit)
);

// File: tb/epp_cycle_seq_tb.sv
module epp_cycle_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int SETTLE     = 2;
  localparam int TMO        = 64;
  localparam int NVEC       = 8;
  localparam int WDOG_CYC   = 50000;

  logic       clk;
  logic       rst_n;
  logic       epp_mode;
  logic       host_cs;
  logic [2:0] host_addr;
  logic       host_rd_n;
  logic       host_wr_n;
  logic [7:0] host_wdata;
  logic [7:0] host_rdata;
  logic       host_rdy;
  logic       timeout_flag;
  logic       pp_write_n;
  logic       pp_astb_n;
  logic       pp_dstb_n;
  logic       pp_wait;
  logic [7:0] pp_din;
  logic [7:0] pp_dout;
  logic       pp_doe;

  epp_cycle_seq #(.SETTLE_CYC(SETTLE), .TIMEOUT_CYC(TMO)) u_dut (
    .clk (clk), .rst_n (rst_n), .epp_mode (epp_mode), .host_cs (host_cs),
    .host_addr (host_addr), .host_rd_n (host_rd_n), .host_wr_n (host_wr_n),
    .host_wdata (host_wdata), .host_rdata (host_rdata), .host_rdy (host_rdy),
    .timeout_flag (timeout_flag), .pp_write_n (pp_write_n),
    .pp_astb_n (pp_astb_n), .pp_dstb_n (pp_dstb_n), .pp_wait (pp_wait),
    .pp_din (pp_din), .pp_dout (pp_dout), .pp_doe (pp_doe)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk;
  int n_bad;
  int cyc;
  bit done;

  // {wr, addr[2:0], wdata[7:0], pdin[7:0], hold[7:0]}; hold 255 = never answer
  localparam logic [27:0] VEC [NVEC] = '{
    {1'b1, 3'd3, 8'hA5, 8'h00, 8'd3},
    {1'b1, 3'd4, 8'h3C, 8'h00, 8'd0},
    {1'b0, 3'd3, 8'h00, 8'h5A, 8'd2},
    {1'b0, 3'd7, 8'h00, 8'hC3, 8'd5},
    {1'b1, 3'd6, 8'hFF, 8'h11, 8'd1},
    {1'b0, 3'd5, 8'h00, 8'h81, 8'd0},
    {1'b1, 3'd7, 8'h00, 8'h99, 8'd4},
    {1'b0, 3'd4, 8'h00, 8'h7E, 8'd255}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WDOG_CYC && !done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, WDOG_CYC);
      finish_run();
    end
  end

  task automatic host_release();
    @(negedge clk);
    host_rd_n = 1'b1;
    host_wr_n = 1'b1;
    host_cs   = 1'b0;
    pp_wait   = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic xfer(input bit wr, input logic [2:0] addr, input logic [7:0] wd,
                      input logic [7:0] pd, input logic [7:0] hold,
                      input bit exp_flag);
    bit is_adr;
    is_adr = (addr == 3'd3);
    @(negedge clk);
    pp_din     = pd;
    host_cs    = 1'b1;
    host_addr  = addr;
    host_wdata = wd;
    if (wr) host_wr_n = 1'b0; else host_rd_n = 1'b0;
    #1;
    chk(host_rdy == 1'b0, "R2 stall", host_rdy, 0);
    for (int i = 0; i < TMO + 40; i++) begin
      @(negedge clk);
      if (!pp_astb_n || !pp_dstb_n) break;
    end
    chk(pp_astb_n == !is_adr && pp_dstb_n == is_adr, "R1 strobe select",
        {pp_astb_n, pp_dstb_n}, {!is_adr, is_adr});
    chk(pp_write_n == !wr, "R4 write level", pp_write_n, !wr);
    if (wr) chk(pp_doe && pp_dout == wd, "R9 drive data", {pp_doe, pp_dout}, {1'b1, wd});
    else    chk(!pp_doe, "R9 no drive on read", pp_doe, 0);
    if (hold != 8'd255) begin
      repeat (hold) @(negedge clk);
      pp_wait = 1'b1;
    end
    for (int i = 0; i < TMO + 40; i++) begin
      @(negedge clk);
      if (host_rdy) break;
    end
    chk(host_rdy && pp_astb_n && pp_dstb_n && pp_write_n && !pp_doe,
        "R5 release", {host_rdy, pp_astb_n, pp_dstb_n, pp_write_n, pp_doe}, 5'b11110);
    if (!wr && hold != 8'd255) chk(host_rdata == pd, "R8 read data", host_rdata, pd);
    chk(timeout_flag == exp_flag, "R6 timeout flag", timeout_flag, exp_flag);
    host_release();
  endtask

  task automatic plain_access(input logic [2:0] addr, input bit wr, input logic [7:0] wd);
    @(negedge clk);
    host_cs = 1'b1; host_addr = addr; host_wdata = wd;
    if (wr) host_wr_n = 1'b0; else host_rd_n = 1'b0;
    #1;
    chk(host_rdy == 1'b1, "R2 no stall", host_rdy, 1);
    repeat (8) @(negedge clk);
    chk(pp_astb_n && pp_dstb_n && pp_write_n, "R2 cable idle",
        {pp_astb_n, pp_dstb_n, pp_write_n}, 3'b111);
  endtask

  initial begin
    bit exp_flag;
    int cnt;
    n_chk = 0; n_bad = 0; cyc = 0; done = 1'b0;
    rst_n = 1'b0; epp_mode = 1'b1; host_cs = 1'b0; host_addr = '0;
    host_rd_n = 1'b1; host_wr_n = 1'b1; host_wdata = '0; pp_wait = 1'b0;
    pp_din = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(host_rdy && pp_write_n && pp_astb_n && pp_dstb_n && !pp_doe && !timeout_flag,
        "R10 reset state",
        {host_rdy, pp_write_n, pp_astb_n, pp_dstb_n, pp_doe, timeout_flag}, 6'b111100);

    // vector table
    exp_flag = 1'b0;
    for (int v = 0; v < NVEC; v++) begin
      if (VEC[v][7:0] == 8'd255) exp_flag = 1'b1;
      xfer(VEC[v][27], VEC[v][26:24], VEC[v][23:16], VEC[v][15:8], VEC[v][7:0], exp_flag);
    end

    // R8 status readback at offset 1, R7 write of zero keeps flag
    @(negedge clk);
    host_cs = 1'b1; host_addr = 3'd1; #1;
    chk(host_rdata == 8'h01, "R8 status read", host_rdata, 8'h01);
    plain_access(3'd1, 1'b1, 8'hFE);
    host_release();
    chk(timeout_flag == 1'b1, "R7 zero write keeps flag", timeout_flag, 1);
    plain_access(3'd1, 1'b1, 8'h01);
    host_release();
    chk(timeout_flag == 1'b0, "R7 one write clears flag", timeout_flag, 0);

    // R6 abort while peripheral never releases, then R7 clear by mode exit
    xfer(1'b1, 3'd5, 8'h42, 8'h00, 8'd255, 1'b1);
    @(negedge clk);
    epp_mode = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(timeout_flag == 1'b0, "R7 mode exit clears flag", timeout_flag, 0);

    // R2 no stall with mode off, nor at offsets 0 and 2
    plain_access(3'd4, 1'b1, 8'h55);
    host_release();
    epp_mode = 1'b1;
    plain_access(3'd0, 1'b0, 8'h00);
    host_release();
    plain_access(3'd2, 1'b1, 8'h00);
    host_release();

    // R3 wait held high at start, then measured settle to write fall
    @(negedge clk);
    pp_wait = 1'b1;
    repeat (4) @(negedge clk);
    host_cs = 1'b1; host_addr = 3'd4; host_wdata = 8'h6D; host_wr_n = 1'b0;
    repeat (12) @(negedge clk);
    chk(pp_write_n && pp_dstb_n && !host_rdy, "R3 hold while wait high",
        {pp_write_n, pp_dstb_n, host_rdy}, 3'b110);
    pp_wait = 1'b0;
    cnt = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      cnt++;
      if (!pp_write_n) break;
    end
    chk(cnt == SETTLE + 3, "R3 settle edges", cnt, SETTLE + 3);
    @(negedge clk);
    chk(!pp_dstb_n, "R4 strobe after write", pp_dstb_n, 0);
    repeat (3) @(negedge clk);
    pp_wait = 1'b1;
    cnt = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      cnt++;
      if (pp_dstb_n) break;
    end
    chk(cnt == SETTLE + 3, "R5 release edges", cnt, SETTLE + 3);
    chk(host_rdy && pp_write_n, "R5 ready with release", {host_rdy, pp_write_n}, 2'b11);
    host_release();

    done = 1'b1;
    finish_run();
  end
endmodule